// File: doc/BRIEF.md
# USB IN-Endpoint Transmit Buffer Controller

This block sits between a small microcontroller and the serial interface engine (SIE) of a USB device. It holds the transmit settings for the control endpoint and for one shared port that serves endpoints 1 to 3. Each setting is a single byte with four fields: stall, transmit enable, data toggle and byte count. Each of the two transmit paths has an 8-byte FIFO. The microcontroller reaches a FIFO through one data register. A circular pointer moves on every access to that register, and a strobe in the buffer-control register sends it back to 0.

When the SIE reports a valid IN token, a small state machine takes a snapshot of the addressed endpoint's settings and gives one response: STALL, NAK or a data packet. A data packet carries its PID type and length. While the packet is sent, the SIE reads bytes through its own index. On a successful transfer the endpoint's transmit enable clears itself. The control endpoint's enable also clears whenever the SIE accepts a SETUP or OUT on that endpoint.

The state machine has three states:
- `S_IDLE` waits for a token. Its transition `tok_seen` captures the snapshot.
- `S_REPLY` presents the response for one cycle. Its transition `to_wait` is taken for a data packet, and `to_idle` is taken for NAK or STALL.
- `S_WAIT_ACK` waits for the outcome. Its transition `ack_ok` clears the enable, and `ack_fail` leaves the enable set. Both return to `S_IDLE`.

Top module: `usb_tx_buf_ctrl`

## Requirements
- R1: After reset, registers 06h, 07h and 0Bh read 00h, both FIFO pointers are 0, and `resp_valid` is 0.
- R2: Control registers are at 06h (control endpoint) and 07h (endpoints 1 to 3). Their fields are:
  - bit 6: stall
  - bit 5: transmit enable
  - bit 4: toggle
  - bits 3:0: byte count
  - bit 7: always reads 0
- R3: If the addressed register has stall set, an IN token is answered with STALL (`resp_code` 2), whatever the enable bit holds.
- R4: If stall and enable are both 0, an IN token is answered with NAK (`resp_code` 1).
- R5: If enable is 1 and stall is 0, the answer is DATA (`resp_code` 3), with `resp_data1` equal to the toggle bit and `resp_len` equal to the byte count. `resp_valid` is high for exactly the one cycle after the token cycle. `resp_code` is 0 when no response is presented.
- R6: `xfer_ok` during `S_WAIT_ACK` clears only the enable bit of the register that served the transfer. `xfer_fail` leaves that register unchanged.
- R7: A pulse on `ctl_setup_out_ok` clears the enable bit at 06h and leaves 07h unchanged.
- R8: FIFO data is at 08h (control endpoint) and 0Ah (endpoints 1 to 3).
  - A read returns the byte at the pointer.
  - Each read or write moves the 3-bit pointer up by one, wrapping from 7 to 0.
  - A write stores the byte at the pointer.
- R9: Writing 0Bh with bit 0 set resets the control-endpoint FIFO pointer. Writing it with bit 1 set resets the other FIFO pointer. 0Bh always reads 00h.
- R10: While `ctl_rx_block` is 1, writes to 08h change neither the FIFO contents nor its pointer.
- R11: `sie_rd_data` returns the byte at `sie_rd_idx` in the FIFO of the endpoint that was last tokened. It does not disturb the microcontroller pointer.
- R12: Address 09h and other unmapped addresses read 00h and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 4 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (moves the FIFO pointer) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| ctl_rx_block | input | 1 | Receive-disable level; blocks writes to 08h |
| in_tok_valid | input | 1 | Valid IN token from the SIE |
| in_tok_ep | input | 2 | Endpoint number of the token |
| xfer_ok | input | 1 | Data packet acknowledged by the host |
| xfer_fail | input | 1 | Data packet not acknowledged |
| ctl_setup_out_ok | input | 1 | Control endpoint accepted a SETUP or OUT |
| resp_valid | output | 1 | Response presented this cycle |
| resp_code | output | 2 | 0 none, 1 NAK, 2 STALL, 3 DATA |
| resp_data1 | output | 1 | 1 = DATA1, 0 = DATA0 |
| resp_len | output | 4 | Byte count of the data packet |
| sie_rd_idx | input | 3 | SIE byte index into the active FIFO |
| sie_rd_data | output | 8 | Byte at `sie_rd_idx` |

## Verification
The bench covers four corner cases:
- **Pointer wrap.** It writes a ninth byte into a FIFO and expects slot 0 to be overwritten. A design with a wider or saturating pointer would return the first byte instead.
- **Blocked write to 08h.** It writes to 08h with `ctl_rx_block` set, then reads back. The read exposes a design that stores the byte or still moves the pointer.
- **Stall with enable set.** It sets stall together with enable and expects STALL. A design that ranked enable above stall would answer DATA.
- **Failed and successful transfers.** The enable must survive a failed transfer and clear after a successful one, and a SETUP/OUT accept must clear only 06h. A design that cleared the wrong register, or cleared on failure, shows up on read-back.

// File: rtl/usbtx_pkg.sv
package usbtx_pkg;

    localparam int BYTE_W    = 8;
    localparam int FIELD_W   = 7;
    localparam int CNT_W     = 4;
    localparam int STALL_BIT = 6;
    localparam int OE_BIT    = 5;
    localparam int SEQ_BIT   = 4;
    localparam int N_PATHS   = 2;

    localparam int ADR_CTL0  = 'h6;
    localparam int ADR_CTL1  = 'h7;
    localparam int ADR_FIFO0 = 'h8;
    localparam int ADR_FIFO1 = 'hA;
    localparam int ADR_BUF   = 'hB;

    typedef enum logic [1:0] {
        RSP_NONE  = 2'd0,
        RSP_NAK   = 2'd1,
        RSP_STALL = 2'd2,
        RSP_DATA  = 2'd3
    } resp_e;

    typedef enum logic [1:0] {
        S_IDLE     = 2'd0,
        S_REPLY    = 2'd1,
        S_WAIT_ACK = 2'd2
    } txst_e;

endpackage

// File: rtl/usbtx_ep_ctrl.sv
module usbtx_ep_ctrl
    import usbtx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [FIELD_W-1:0] wdata,
    input  logic               clr_oe,
    output logic [FIELD_W-1:0] ctrl_q
);

    logic [FIELD_W-1:0] ctrl_nxt;

    always_comb begin
        ctrl_nxt = wr_en ? wdata : ctrl_q;
        if (clr_oe) begin
            ctrl_nxt[OE_BIT] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_nxt;
        end
    end

    // R6/R7: a hardware clear always leaves the enable low afterwards
    p_oe_cleared_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_oe |=> !ctrl_q[OE_BIT]);

    // R2: the register only changes through a write or a clear
    p_ctrl_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !clr_oe) |=> $stable(ctrl_q));

endmodule

// File: rtl/usbtx_fifo.sv
module usbtx_fifo
    import usbtx_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_wr,
    input  logic              acc_rd,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              ptr_clr,
    output logic [BYTE_W-1:0] rdata,
    output logic [PTR_W-1:0]  ptr_q,
    input  logic [PTR_W-1:0]  sie_idx,
    output logic [BYTE_W-1:0] sie_data
);

    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [BYTE_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  ptr_nxt;

    always_comb begin
        ptr_nxt = ptr_q;
        if (ptr_clr) begin
            ptr_nxt = '0;
        end else if (acc_wr || acc_rd) begin
            ptr_nxt = (ptr_q == LAST) ? '0 : ptr_q + PTR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_nxt;
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[i] <= '0;
            end else if (acc_wr && ptr_q == PTR_W'(i)) begin
                mem[i] <= wdata;
            end
        end
    end

    assign rdata    = mem[ptr_q];
    assign sie_data = mem[sie_idx];

    // R8: every access moves the pointer
    p_ptr_moves_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((acc_wr || acc_rd) && !ptr_clr) |=> (ptr_q != $past(ptr_q)));

    // R11: without access or clear, the pointer holds
    p_ptr_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_wr && !acc_rd && !ptr_clr) |=> $stable(ptr_q));

    // R9: a reset strobe leaves the pointer at zero
    p_ptr_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_clr |=> (ptr_q == '0));

endmodule

// File: rtl/usbtx_resp_fsm.sv
module usbtx_resp_fsm
    import usbtx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_tok_valid,
    input  logic [1:0]         in_tok_ep,
    input  logic [FIELD_W-1:0] ctrl0,
    input  logic [FIELD_W-1:0] ctrl1,
    input  logic               xfer_ok,
    input  logic               xfer_fail,
    output logic               resp_valid,
    output logic [1:0]         resp_code,
    output logic               resp_data1,
    output logic [CNT_W-1:0]   resp_len,
    output logic               sel_q,
    output logic [N_PATHS-1:0] clr_oe
);

    txst_e              state, state_nxt;
    resp_e              code_q;
    logic               tok_sel;
    logic [FIELD_W-1:0] tok_ctrl;
    resp_e              tok_code;

    assign tok_sel  = (in_tok_ep != 2'd0);
    assign tok_ctrl = tok_sel ? ctrl1 : ctrl0;

    always_comb begin
        if (tok_ctrl[STALL_BIT]) begin
            tok_code = RSP_STALL;
        end else if (tok_ctrl[OE_BIT]) begin
            tok_code = RSP_DATA;
        end else begin
            tok_code = RSP_NAK;
        end
    end

    // next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            S_IDLE:     if (in_tok_valid) state_nxt = S_REPLY;        // tok_seen
            S_REPLY:    state_nxt = (code_q == RSP_DATA) ? S_WAIT_ACK // to_wait
                                                         : S_IDLE;    // to_idle
            S_WAIT_ACK: if (xfer_ok || xfer_fail) state_nxt = S_IDLE; // ack_ok / ack_fail
            default:    state_nxt = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // outputs: snapshot taken at token time, strobes decoded from state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q     <= RSP_NONE;
            resp_data1 <= 1'b0;
            resp_len   <= '0;
            sel_q      <= 1'b0;
        end else if (state == S_IDLE && in_tok_valid) begin
            code_q     <= tok_code;
            resp_data1 <= tok_ctrl[SEQ_BIT];
            resp_len   <= tok_ctrl[CNT_W-1:0];
            sel_q      <= tok_sel;
        end
    end

    always_comb begin
        resp_valid = (state == S_REPLY);
        resp_code  = resp_valid ? code_q : RSP_NONE;
        clr_oe     = '0;
        if (state == S_WAIT_ACK && xfer_ok) begin
            clr_oe[sel_q] = 1'b1;
        end
    end

    // R5: the response is a single-cycle pulse
    p_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    // R3: stall wins over everything
    p_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && in_tok_valid && tok_ctrl[STALL_BIT])
        |=> (resp_code == RSP_STALL));

    // R4: neither stall nor enable gives NAK
    p_nak_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && in_tok_valid && !tok_ctrl[STALL_BIT] && !tok_ctrl[OE_BIT])
        |=> (resp_code == RSP_NAK));

    // R6: a transfer outcome always returns to idle
    p_ack_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT_ACK && (xfer_ok || xfer_fail)) |=> (state == S_IDLE));

endmodule

// File: rtl/usb_tx_buf_ctrl.sv
module usb_tx_buf_ctrl
    import usbtx_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int FIFO_DEPTH = 8,
    parameter int IDX_W      = $clog2(FIFO_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic              ctl_rx_block,
    input  logic              in_tok_valid,
    input  logic [1:0]        in_tok_ep,
    input  logic              xfer_ok,
    input  logic              xfer_fail,
    input  logic              ctl_setup_out_ok,
    output logic              resp_valid,
    output logic [1:0]        resp_code,
    output logic              resp_data1,
    output logic [CNT_W-1:0]  resp_len,
    input  logic [IDX_W-1:0]  sie_rd_idx,
    output logic [BYTE_W-1:0] sie_rd_data
);

    localparam logic [ADDR_W-1:0] A_CTL [N_PATHS] = '{ADDR_W'(ADR_CTL0), ADDR_W'(ADR_CTL1)};
    localparam logic [ADDR_W-1:0] A_FIFO[N_PATHS] = '{ADDR_W'(ADR_FIFO0), ADDR_W'(ADR_FIFO1)};
    localparam logic [ADDR_W-1:0] A_BUF = ADDR_W'(ADR_BUF);

    logic [FIELD_W-1:0] ctrl_w    [N_PATHS];
    logic [BYTE_W-1:0]  fifo_rd_w [N_PATHS];
    logic [BYTE_W-1:0]  sie_w     [N_PATHS];
    logic [IDX_W-1:0]   ptr_w     [N_PATHS];
    logic [N_PATHS-1:0] ctl_wr, fifo_wr, fifo_rd, ptr_clr, hw_clr, clr_from_fsm;
    logic               sel_q;

    for (genvar g = 0; g < N_PATHS; g++) begin : g_path
        logic wr_gate;
        if (g == 0) begin : g_ctl
            assign wr_gate = !ctl_rx_block;
            assign hw_clr[g] = clr_from_fsm[g] | ctl_setup_out_ok;
        end else begin : g_shr
            assign wr_gate = 1'b1;
            assign hw_clr[g] = clr_from_fsm[g];
        end

        assign ctl_wr[g]  = reg_wr && reg_addr == A_CTL[g];
        assign fifo_wr[g] = reg_wr && reg_addr == A_FIFO[g] && wr_gate;
        assign fifo_rd[g] = reg_rd && reg_addr == A_FIFO[g];
        assign ptr_clr[g] = reg_wr && reg_addr == A_BUF && reg_wdata[g];

        usbtx_ep_ctrl u_ctrl (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (ctl_wr[g]),
            .wdata  (reg_wdata[FIELD_W-1:0]),
            .clr_oe (hw_clr[g]),
            .ctrl_q (ctrl_w[g])
        );

        usbtx_fifo #(.DEPTH(FIFO_DEPTH), .PTR_W(IDX_W)) u_fifo (
            .clk      (clk),
            .rst_n    (rst_n),
            .acc_wr   (fifo_wr[g]),
            .acc_rd   (fifo_rd[g]),
            .wdata    (reg_wdata),
            .ptr_clr  (ptr_clr[g]),
            .rdata    (fifo_rd_w[g]),
            .ptr_q    (ptr_w[g]),
            .sie_idx  (sie_rd_idx),
            .sie_data (sie_w[g])
        );
    end

    usbtx_resp_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_tok_valid (in_tok_valid),
        .in_tok_ep    (in_tok_ep),
        .ctrl0        (ctrl_w[0]),
        .ctrl1        (ctrl_w[1]),
        .xfer_ok      (xfer_ok),
        .xfer_fail    (xfer_fail),
        .resp_valid   (resp_valid),
        .resp_code    (resp_code),
        .resp_data1   (resp_data1),
        .resp_len     (resp_len),
        .sel_q        (sel_q),
        .clr_oe       (clr_from_fsm)
    );

    always_comb begin
        reg_rdata = '0;
        for (int p = 0; p < N_PATHS; p++) begin
            if (reg_addr == A_CTL[p])  reg_rdata = {1'b0, ctrl_w[p]};
            if (reg_addr == A_FIFO[p]) reg_rdata = fifo_rd_w[p];
        end
    end

    assign sie_rd_data = sie_w[sel_q];

    // R10: a blocked write leaves the control-endpoint pointer alone
    p_rx_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_FIFO[0] && ctl_rx_block) |=> $stable(ptr_w[0]));

    // R7: a SETUP/OUT accept never touches the shared-port register
    p_setup_only_ep0_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_setup_out_ok && !ctl_wr[1] && !clr_from_fsm[1]) |=> $stable(ctrl_w[1]));

endmodule

// File: tb/tb_usb_tx_buf_ctrl.sv
module tb_usb_tx_buf_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] reg_addr = '0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       ctl_rx_block = 1'b0;
    logic       in_tok_valid = 1'b0;
    logic [1:0] in_tok_ep = '0;
    logic       xfer_ok = 1'b0, xfer_fail = 1'b0, ctl_setup_out_ok = 1'b0;
    logic       resp_valid, resp_data1;
    logic [1:0] resp_code;
    logic [3:0] resp_len;
    logic [2:0] sie_rd_idx = '0;
    logic [7:0] sie_rd_data;

    int n_checks = 0;
    int n_errs   = 0;

    always #10 clk = ~clk;

    usb_tx_buf_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ctl_rx_block(ctl_rx_block), .in_tok_valid(in_tok_valid),
        .in_tok_ep(in_tok_ep), .xfer_ok(xfer_ok), .xfer_fail(xfer_fail),
        .ctl_setup_out_ok(ctl_setup_out_ok), .resp_valid(resp_valid),
        .resp_code(resp_code), .resp_data1(resp_data1), .resp_len(resp_len),
        .sie_rd_idx(sie_rd_idx), .sie_rd_data(sie_rd_data)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errs++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #2 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    // raise a token for one cycle; return what is presented the next cycle
    task automatic token(input logic [1:0] ep, output logic v, output logic [1:0] c,
                         output logic d1, output logic [3:0] len);
        @(negedge clk);
        in_tok_valid = 1'b1; in_tok_ep = ep;
        @(negedge clk);
        in_tok_valid = 1'b0;
        v = resp_valid; c = resp_code; d1 = resp_data1; len = resp_len;
    endtask

    task automatic outcome(input logic ok);
        @(negedge clk);
        xfer_ok = ok; xfer_fail = !ok;
        @(negedge clk);
        xfer_ok = 1'b0; xfer_fail = 1'b0;
    endtask

    task automatic t_reset;
        logic [7:0] d;
        check("R1 resp_valid", resp_valid, 0);
        rd(4'h6, d); check("R1 reg06", d, 8'h00);
        rd(4'h7, d); check("R1 reg07", d, 8'h00);
        rd(4'hB, d); check("R1 reg0B", d, 8'h00);
    endtask

    task automatic t_layout;
        logic [7:0] d;
        wr(4'h6, 8'hFF); rd(4'h6, d); check("R2 bit7 masked", d, 8'h7F);
        wr(4'h7, 8'hA5); rd(4'h7, d); check("R2 reg07", d, 8'h25);
    endtask

    task automatic t_nak;
        logic v, d1; logic [1:0] c; logic [3:0] l;
        wr(4'h6, 8'h0C);
        token(2'd0, v, c, d1, l);
        check("R4 valid", v, 1); check("R4 NAK", c, 1);
        @(negedge clk); check("R5 pulse ends", resp_valid, 0);
        check("R5 code idle", resp_code, 0);
    endtask

    task automatic t_fifo_wrap;
        logic [7:0] d;
        wr(4'hB, 8'h01);
        for (int i = 0; i < 8; i++) wr(4'h8, 8'h10 + 8'(i));
        wr(4'h8, 8'hAA);                  // ninth write wraps onto slot 0
        wr(4'hB, 8'h01);
        rd(4'h8, d); check("R8 wrap slot0", d, 8'hAA);
        rd(4'h8, d); check("R8 slot1", d, 8'h11);
        rd(4'hB, d); check("R9 reads zero", d, 8'h00);
    endtask

    task automatic t_rx_block;
        logic [7:0] d;
        wr(4'hB, 8'h01);
        ctl_rx_block = 1'b1;
        wr(4'h8, 8'h55);
        ctl_rx_block = 1'b0;
        rd(4'h8, d); check("R10 data kept", d, 8'hAA);
        rd(4'h8, d); check("R10 ptr kept", d, 8'h11);
    endtask

    task automatic t_data_ep0;
        logic v, d1; logic [1:0] c; logic [3:0] l; logic [7:0] d;
        wr(4'h6, 8'h38);
        token(2'd0, v, c, d1, l);
        check("R5 DATA", c, 3); check("R5 DATA1", d1, 1); check("R5 len", l, 8);
        sie_rd_idx = 3'd3; #1 check("R11 idx3", sie_rd_data, 8'h13);
        sie_rd_idx = 3'd0; #1 check("R11 idx0", sie_rd_data, 8'hAA);
        outcome(1'b0);
        rd(4'h6, d); check("R6 fail keeps enable", d, 8'h38);
        token(2'd0, v, c, d1, l);
        outcome(1'b1);
        rd(4'h6, d); check("R6 ok clears enable", d, 8'h18);
        rd(4'h8, d); check("R11 ptr untouched", d, 8'h12);
    endtask

    task automatic t_stall;
        logic v, d1; logic [1:0] c; logic [3:0] l;
        wr(4'h7, 8'h62);
        token(2'd2, v, c, d1, l); check("R3 stall over enable", c, 2);
        wr(4'h7, 8'h40);
        token(2'd1, v, c, d1, l); check("R3 stall", c, 2);
    endtask

    task automatic t_data_shared;
        logic v, d1; logic [1:0] c; logic [3:0] l; logic [7:0] d;
        wr(4'hB, 8'h02);
        for (int i = 0; i < 4; i++) wr(4'hA, 8'h80 + 8'(i));
        wr(4'h6, 8'h27);
        wr(4'h7, 8'h24);
        token(2'd3, v, c, d1, l);
        check("R5 shared DATA", c, 3); check("R5 DATA0", d1, 0); check("R5 len4", l, 4);
        sie_rd_idx = 3'd2; #1 check("R11 shared idx2", sie_rd_data, 8'h82);
        outcome(1'b1);
        rd(4'h7, d); check("R6 reg07 cleared", d, 8'h04);
        rd(4'h6, d); check("R6 reg06 untouched", d, 8'h27);
        wr(4'hB, 8'h02);
        rd(4'hA, d); check("R9 ptr1 reset", d, 8'h80);
    endtask

    task automatic t_setup_clear;
        logic [7:0] d;
        wr(4'h6, 8'h25); wr(4'h7, 8'h25);
        @(negedge clk); ctl_setup_out_ok = 1'b1;
        @(negedge clk); ctl_setup_out_ok = 1'b0;
        rd(4'h6, d); check("R7 reg06 cleared", d, 8'h05);
        rd(4'h7, d); check("R7 reg07 kept", d, 8'h25);
    endtask

    task automatic t_unmapped;
        logic [7:0] d;
        wr(4'h9, 8'h5A);
        rd(4'h9, d); check("R12 reg09 zero", d, 8'h00);
        rd(4'h6, d); check("R12 no side effect", d, 8'h05);
    endtask

    initial begin : watchdog
        #2_000_000;
        n_checks++; n_errs++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_layout;
        t_nak;
        t_fifo_wrap;
        t_rx_block;
        t_data_ep0;
        t_stall;
        t_data_shared;
        t_setup_clear;
        t_unmapped;
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

endmodule